// File: doc/BRIEF.md
# Microcoded Control Sequencer with Opcode Dispatch

This block drives a multicycle datapath from a writable control store. A microprogram counter selects one control word for each state. The upper part of the word goes out as the datapath control signals. The low two bits form a sequencing code that selects the next microaddress. The code can advance the counter, send it back to the fetch state at address 0, or jump through one of two opcode-indexed dispatch tables. No word stores an explicit next-state number, so each state needs exactly one word, however many exits it has.

The control store and both dispatch tables are loaded through one synchronous write port. That port is accepted only while reset is held. A dispatch entry that has not been loaded since the last table clear resolves to address 0, so an unknown opcode falls back to fetch. The control signals are registered. They show the word of a microaddress one clock after the counter reaches that address.

Top module: `uctrl_seq`

## Requirements
- R1: While `rst` is high, `uaddr` is 0. From the first clock edge of reset onward, `ctl_sig` is 0.
- R2: A control word is 19 bits. Bits [18:2] are the control signals and bits [1:0] are the sequencing code. `ctl_sig` equals bits [18:2] of the word at the microaddress held during the previous cycle.
- R3: Sequencing code 2'b11 moves to the current microaddress plus one, and wraps from 15 to 0.
- R4: Sequencing code 2'b00 moves to microaddress 0.
- R5: Sequencing code 2'b01 moves to the entry of dispatch table A indexed by `opcode`.
- R6: Sequencing code 2'b10 moves to the entry of dispatch table B indexed by `opcode`.
- R7: A dispatch through an entry that has not been written since the last table clear moves to microaddress 0.
- R8: The write port acts only when `rst` and `wr_en` are both high. For `wr_sel` 2'b00, `wr_data` is stored as the word at `wr_addr[3:0]`. For 2'b01 and 2'b10, `wr_data[3:0]` becomes the target at `wr_addr` in table A or table B, and that entry is marked defined. For 2'b11, every entry of both tables becomes undefined. Writes made while `rst` is low have no effect.
- R9: With opcode 6'b100011, table A maps to 2, table B maps to 3, and the codes of words 0 to 4 are 11, 01, 10, 11, 00. The microaddress then visits 0, 1, 2, 3, 4, 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also enables loading |
| opcode | input | 6 | Opcode that indexes the dispatch tables |
| wr_en | input | 1 | Load strobe |
| wr_sel | input | 2 | Load target: store, table A, table B, clear tables |
| wr_addr | input | 6 | Word address or table index |
| wr_data | input | 19 | Control word, or target in bits [3:0] |
| ctl_sig | output | 17 | Registered datapath control signals |
| uaddr | output | 4 | Current microaddress |

## Verification
The hardest case to reach from the ports is the counter wrapping from 15 to 0. No realistic microprogram runs sequentially into the top word. The stimulus sets up this case by mapping one opcode in table A to address 14 and giving words 14 and 15 the increment code, so the run passes through 15 and wraps. Writes that should be ignored are made while the sequencer runs. Their absence is then seen after a fresh reset, in the control signals of the word and in the path taken through the table entry that was targeted.

// File: rtl/uctrl_pkg.sv
package uctrl_pkg;

  // Sequencing code held in the low bits of each control word.
  typedef enum logic [1:0] {
    SEQ_FETCH  = 2'b00,
    SEQ_DISP_A = 2'b01,
    SEQ_DISP_B = 2'b10,
    SEQ_NEXT   = 2'b11
  } seq_e;

  // Target of a load through the write port.
  typedef enum logic [1:0] {
    WSEL_STORE = 2'b00,
    WSEL_TAB_A = 2'b01,
    WSEL_TAB_B = 2'b10,
    WSEL_CLEAR = 2'b11
  } wsel_e;

  localparam int unsigned SEQ_W = 2;
  localparam int unsigned N_TABLES = 2;

endpackage

// File: rtl/uctrl_store.sv
module uctrl_store
  import uctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned SIG_W  = 17
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [SIG_W+SEQ_W-1:0]  wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [SEQ_W-1:0]        seq_code,
  output logic [SIG_W-1:0]        sig_q
);
  localparam int unsigned WORD_W = SIG_W + SEQ_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] cur_word;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign cur_word = mem[raddr];
  assign seq_code = cur_word[SEQ_W-1:0];

  // Control signals are registered: one cycle behind the microaddress.
  always_ff @(posedge clk) begin
    if (rst) sig_q <= '0;
    else     sig_q <= cur_word[WORD_W-1:SEQ_W];
  end

endmodule

// File: rtl/uctrl_dispatch.sv
module uctrl_dispatch #(
  parameter int unsigned OPC_W  = 6,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic              clr,
  input  logic [OPC_W-1:0]  waddr,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] target,
  output logic              hit
);
  localparam int unsigned DEPTH = 1 << OPC_W;

  logic [ADDR_W-1:0] tgt_mem [DEPTH];
  logic [DEPTH-1:0]  defined;

  always_ff @(posedge clk) begin
    if (we) tgt_mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (clr)     defined <= '0;
    else if (we) defined[waddr] <= 1'b1;
  end

  assign hit    = defined[opcode];
  assign target = hit ? tgt_mem[opcode] : '0;

endmodule

// File: rtl/uctrl_next.sv
module uctrl_next
  import uctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [SEQ_W-1:0]  seq_code,
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] tgt_a,
  input  logic [ADDR_W-1:0] tgt_b,
  output logic [ADDR_W-1:0] nxt
);

  function automatic logic [ADDR_W-1:0] pick_next(
    input logic [SEQ_W-1:0]  code,
    input logic [ADDR_W-1:0] here,
    input logic [ADDR_W-1:0] a,
    input logic [ADDR_W-1:0] b
  );
    logic [ADDR_W-1:0] r;
    case (seq_e'(code))
      SEQ_NEXT:   r = here + 1'b1;
      SEQ_DISP_A: r = a;
      SEQ_DISP_B: r = b;
      default:    r = '0;
    endcase
    return r;
  endfunction

  assign nxt = pick_next(seq_code, cur, tgt_a, tgt_b);

endmodule

// File: rtl/uctrl_seq.sv
module uctrl_seq
  import uctrl_pkg::*;
#(
  parameter int unsigned OPC_W  = 6,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned SIG_W  = 17
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [OPC_W-1:0]       opcode,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [OPC_W-1:0]       wr_addr,
  input  logic [SIG_W+SEQ_W-1:0] wr_data,
  output logic [SIG_W-1:0]       ctl_sig,
  output logic [ADDR_W-1:0]      uaddr
);
  localparam int unsigned WORD_W = SIG_W + SEQ_W;

  wsel_e             sel;
  logic              load_ok;
  logic              store_we;
  logic              tab_clr;
  logic [N_TABLES-1:0] tab_we;
  logic [ADDR_W-1:0] disp_tgt [N_TABLES];
  logic [N_TABLES-1:0] disp_hit;
  logic [SEQ_W-1:0]  seq_code;
  logic [ADDR_W-1:0] upc;
  logic [ADDR_W-1:0] upc_nxt;

  assign sel      = wsel_e'(wr_sel);
  assign load_ok  = rst & wr_en;
  assign store_we = load_ok && (sel == WSEL_STORE);
  assign tab_clr  = load_ok && (sel == WSEL_CLEAR);
  assign tab_we[0] = load_ok && (sel == WSEL_TAB_A);
  assign tab_we[1] = load_ok && (sel == WSEL_TAB_B);

  uctrl_store #(.ADDR_W(ADDR_W), .SIG_W(SIG_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .we       (store_we),
    .waddr    (wr_addr[ADDR_W-1:0]),
    .wdata    (wr_data),
    .raddr    (upc),
    .seq_code (seq_code),
    .sig_q    (ctl_sig)
  );

  for (genvar g = 0; g < N_TABLES; g++) begin : g_tab
    uctrl_dispatch #(.OPC_W(OPC_W), .ADDR_W(ADDR_W)) u_tab (
      .clk    (clk),
      .we     (tab_we[g]),
      .clr    (tab_clr),
      .waddr  (wr_addr),
      .wdata  (wr_data[ADDR_W-1:0]),
      .opcode (opcode),
      .target (disp_tgt[g]),
      .hit    (disp_hit[g])
    );
  end

  uctrl_next #(.ADDR_W(ADDR_W)) u_next (
    .seq_code (seq_code),
    .cur      (upc),
    .tgt_a    (disp_tgt[0]),
    .tgt_b    (disp_tgt[1]),
    .nxt      (upc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) upc <= '0;
    else     upc <= upc_nxt;
  end

  assign uaddr = upc;

  AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (rst)
    (seq_code == SEQ_FETCH) |=> (uaddr == '0)); // R4
  AST_SEQ_INC: assert property (@(posedge clk) disable iff (rst)
    (seq_code == SEQ_NEXT) |=> (uaddr == ADDR_W'($past(uaddr) + 1'b1))); // R3
  AST_DISP_A: assert property (@(posedge clk) disable iff (rst)
    (seq_code == SEQ_DISP_A) |=> (uaddr == $past(disp_tgt[0]))); // R5
  AST_DISP_B: assert property (@(posedge clk) disable iff (rst)
    (seq_code == SEQ_DISP_B) |=> (uaddr == $past(disp_tgt[1]))); // R6
  AST_UNDEF_FETCH: assert property (@(posedge clk) disable iff (rst)
    (seq_code == SEQ_DISP_A && !disp_hit[0]) |=> (uaddr == '0)); // R7

endmodule

// File: tb/uctrl_seq_test.sv
module uctrl_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [5:0]  wr_addr = '0;
  logic [18:0] wr_data = '0;
  logic [16:0] ctl_sig;
  logic [3:0]  uaddr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [16:0] bsig [16];
  logic [1:0]  bseq [16];

  always #5 clk = ~clk;

  uctrl_seq uut (
    .clk(clk), .rst(rst), .opcode(opcode), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .ctl_sig(ctl_sig), .uaddr(uaddr)
  );

  // {opcode, steps, visited addresses s5..s0}
  localparam logic [33:0] VECS [7] = '{
    {6'b100011, 4'd5, 24'h043210},   // load path
    {6'b101011, 4'd4, 24'h005210},   // store path
    {6'b000000, 4'd4, 24'h007610},   // register op
    {6'b000100, 4'd3, 24'h000810},   // branch
    {6'b000010, 4'd3, 24'h000910},   // jump
    {6'b111111, 4'd4, 24'h00FE10},   // wrap 15 -> 0
    {6'b010101, 4'd2, 24'h000010}    // undefined entry
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] sel, input logic [5:0] a, input logic [18:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put_word(input int i, input logic [16:0] s, input logic [1:0] c);
    bsig[i] = s; bseq[i] = c;
    load(2'b00, 6'(i), {s, c});
  endtask

  // Starts with uaddr at 0 and rst low; walks the expected addresses.
  task automatic walk(input logic [5:0] op, input int steps, input logic [23:0] seq, input string tag);
    opcode = op;
    for (int k = 0; k < steps; k++) begin
      @(posedge clk); #1;
      check({tag, " uaddr"}, 32'(uaddr), 32'(seq[4*(k+1) +: 4]));
      check("R2 ctl_sig", 32'(ctl_sig), 32'(bsig[seq[4*k +: 4]]));
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset uaddr", 32'(uaddr), 0);
    check("R1 reset ctl_sig", 32'(ctl_sig), 0);

    load(2'b11, 6'd0, '0);
    put_word(0, 17'b10010100000001000, 2'b11);
    put_word(1, 17'b00000000010011000, 2'b01);
    put_word(2, 17'b00000000000010100, 2'b10);
    put_word(3, 17'b00110000000010100, 2'b11);
    put_word(4, 17'b00110000000010110, 2'b00);
    put_word(5, 17'b00101000000010100, 2'b00);
    put_word(6, 17'b00000000001000100, 2'b11);
    put_word(7, 17'b00000000001000111, 2'b00);
    put_word(8, 17'b01000000100100100, 2'b00);
    put_word(9, 17'b10000001000000000, 2'b00);
    for (int i = 10; i < 16; i++)
      put_word(i, 17'(i * 613 + 77), (i >= 14) ? 2'b11 : 2'b00);
    load(2'b01, 6'b100011, 19'd2);
    load(2'b10, 6'b100011, 19'd3);
    load(2'b01, 6'b101011, 19'd2);
    load(2'b10, 6'b101011, 19'd5);
    load(2'b01, 6'b000000, 19'd6);
    load(2'b01, 6'b000100, 19'd8);
    load(2'b01, 6'b000010, 19'd9);
    load(2'b01, 6'b111111, 19'd14);

    @(negedge clk);
    check("R1 held uaddr", 32'(uaddr), 0);
    rst = 1'b0;

    // R9 load path, R5/R6 dispatch, R3 increment and wrap, R4 fetch, R7 undefined
    for (int v = 0; v < 7; v++)
      walk(VECS[v][33:28], int'(VECS[v][27:24]), VECS[v][23:0], "R3/R4/R5/R6/R7/R9");

    // R8: writes while running are ignored
    opcode = 6'b010101;
    load(2'b00, 6'd1, 19'h7FFFF);
    load(2'b01, 6'b010101, 19'd9);
    load(2'b10, 6'b100011, 19'd7);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset after run uaddr", 32'(uaddr), 0);
    check("R1 reset after run ctl_sig", 32'(ctl_sig), 0);
    rst = 1'b0;
    walk(6'b010101, 2, 24'h000010, "R8 ignored write");
    walk(6'b100011, 5, 24'h043210, "R8 ignored write table B");

    // R8: clear command makes every entry undefined, R7 fallback
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    load(2'b11, 6'd0, '0);
    @(negedge clk);
    rst = 1'b0;
    walk(6'b100011, 2, 24'h000010, "R8 clear");
    walk(6'b000000, 2, 24'h000010, "R7 after clear");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule